// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the integer multiply and divide engine of a 32-bit pipelined core. It owns two result registers, HI and LO. A start strobe, together with a 6-bit function code and two operands, launches an operation. The operands are `rs_val` and `rt_val`.

A multiply runs as an iterative shift-add loop. It leaves the upper half of the 64-bit product in HI and the lower half in LO. A divide runs as a restoring loop. It leaves the quotient in LO and the remainder in HI. Both come in signed and unsigned forms. Two further codes copy `rs_val` straight into HI or into LO in a single cycle.

The pipeline reads HI or LO through a combinational read port. While a multiply or divide is in flight, `busy` is high. A read raised in that window is told to stall, so it never consumes a stale value. Signed division truncates toward zero, and the remainder carries the sign of the dividend. A division by zero still takes the full iteration time but leaves HI and LO untouched.

Top module: `hilo_muldiv`

## Requirements
- R1: With start high and function code 24, HI:LO receives the signed 64-bit product of rs_val and rt_val, HI holding bits 63..32.
- R2: Function code 25 forms the same split product with both operands treated as unsigned.
- R3: Function code 26 writes the signed quotient of rs_val/rt_val, truncated toward zero, into LO. It writes the remainder, which carries the sign of rs_val, into HI.
- R4: Function code 27 writes the unsigned quotient into LO and the unsigned remainder into HI.
- R5: Function code 17 copies rs_val into HI and code 19 copies it into LO, at the clock edge that samples start. Neither raises busy.
- R6: rd_data shows HI when rd_hi is 1 and LO when rd_hi is 0 (codes 16 and 18 of the core map to these two reads).
- R7: After the edge that accepts a multiply or divide, busy is high for exactly 32 cycles. HI and LO keep their old values until the edge on which busy falls.
- R8: A divide (code 26 or 27) with rt_val equal to zero leaves HI and LO unchanged, and busy still clears after 32 cycles.
- R9: rd_stall is high exactly when rd_req and busy are both high.
- R10: A start while busy is high is ignored, as is a start carrying any code other than 17, 19, 24, 25, 26 or 27. HI, LO and busy are left as they were.
- R11: Synchronous reset clears HI, LO and busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe, sampled when busy is low |
| funct | input | 6 | Operation function code |
| rs_val | input | 32 | First operand (multiplicand, dividend, or move source) |
| rt_val | input | 32 | Second operand (multiplier or divisor) |
| rd_req | input | 1 | Pipeline wants to read HI or LO this cycle |
| rd_hi | input | 1 | Read select: 1 for HI, 0 for LO |
| rd_data | output | 32 | Selected result register |
| rd_stall | output | 1 | Read must wait for the operation in flight |
| busy | output | 1 | Multiply or divide in progress |

## Verification
All four arithmetic codes are swept over every pair drawn from a set of boundary values. The set includes zero, one, minus one, minus two, the largest positive and the most negative word, and mixed-sign small values. Across these pairs, the sign fix-up of each signed variant is told apart from its unsigned twin. The most-negative-by-minus-one divide separates a correct 32-bit wrap from a saturating one. The zero divisors show whether HI and LO survive. Separate cases cover a start issued mid-run, an unknown function code, the stall flag during a run, and a mid-run look at HI, which must hold its old value.

// File: rtl/hilo_muldiv_pkg.sv
package hilo_muldiv_pkg;

    localparam int FUNCT_W = 6;

    localparam logic [FUNCT_W-1:0] FN_MTHI  = 6'd17;
    localparam logic [FUNCT_W-1:0] FN_MTLO  = 6'd19;
    localparam logic [FUNCT_W-1:0] FN_MULT  = 6'd24;
    localparam logic [FUNCT_W-1:0] FN_MULTU = 6'd25;
    localparam logic [FUNCT_W-1:0] FN_DIV   = 6'd26;
    localparam logic [FUNCT_W-1:0] FN_DIVU  = 6'd27;

    typedef struct packed {
        logic is_mul;
        logic is_div;
        logic signed_op;
        logic wr_hi;
        logic wr_lo;
    } op_dec_t;

    typedef struct packed {
        logic is_div;
        logic neg_main;
        logic neg_rem;
        logic div_zero;
    } job_t;

    function automatic op_dec_t decode_funct(input logic [FUNCT_W-1:0] f);
        op_dec_t d;
        d = '0;
        case (f)
            FN_MULT:  begin d.is_mul = 1'b1; d.signed_op = 1'b1; end
            FN_MULTU: d.is_mul = 1'b1;
            FN_DIV:   begin d.is_div = 1'b1; d.signed_op = 1'b1; end
            FN_DIVU:  d.is_div = 1'b1;
            FN_MTHI:  d.wr_hi = 1'b1;
            FN_MTLO:  d.wr_lo = 1'b1;
            default:  d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/hilo_mul_iter.sv
module hilo_mul_iter #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] prod_nxt
);
    logic [W-1:0]   mcand_q;
    logic [2*W-1:0] prod_q;
    logic [W:0]     partial;

    always_comb begin
        partial  = {1'b0, prod_q[2*W-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : '0);
        prod_nxt = {partial, prod_q[W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (load) begin
            mcand_q <= mcand_in;
            prod_q  <= {{W{1'b0}}, mplier_in};
        end else if (step) begin
            prod_q  <= prod_nxt;
        end
    end
endmodule

// File: rtl/hilo_div_iter.sv
module hilo_div_iter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dividend_in,
    input  logic [W-1:0] divisor_in,
    output logic [W-1:0] quo_nxt,
    output logic [W-1:0] rem_nxt
);
    logic [W-1:0] dsor_q;
    logic [W-1:0] rem_q;
    logic [W-1:0] quo_q;
    logic [W:0]   shifted;
    logic [W:0]   trial;
    logic         fits;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = shifted - {1'b0, dsor_q};
        fits    = ~trial[W];
        rem_nxt = fits ? trial[W-1:0] : shifted[W-1:0];
        quo_nxt = {quo_q[W-2:0], fits};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dsor_q <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
        end else if (load) begin
            dsor_q <= divisor_in;
            rem_q  <= '0;
            quo_q  <= dividend_in;
        end else if (step) begin
            rem_q  <= rem_nxt;
            quo_q  <= quo_nxt;
        end
    end
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
    import hilo_muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FUNCT_W-1:0] funct,
    input  logic [W-1:0]       rs_val,
    input  logic [W-1:0]       rt_val,
    input  logic               rd_req,
    input  logic               rd_hi,
    output logic [W-1:0]       rd_data,
    output logic               rd_stall,
    output logic               busy
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [W-1:0]   hi_q, lo_q;
    logic           busy_q;
    logic [CNT_W-1:0] cnt_q;
    job_t           job_q;
    op_dec_t        dec;
    logic           accept, launch, finish;
    logic           a_neg, b_neg;
    logic [W-1:0]   a_mag, b_mag;
    logic [2*W-1:0] prod_nxt, prod_fix;
    logic [W-1:0]   quo_nxt, rem_nxt, quo_fix, rem_fix;

    always_comb begin
        dec    = decode_funct(funct);
        accept = start && !busy_q;
        launch = accept && (dec.is_mul || dec.is_div);
        finish = busy_q && (cnt_q == LAST);
        a_neg  = dec.signed_op && rs_val[W-1];
        b_neg  = dec.signed_op && rt_val[W-1];
        a_mag  = a_neg ? (~rs_val + 1'b1) : rs_val;
        b_mag  = b_neg ? (~rt_val + 1'b1) : rt_val;
        prod_fix = job_q.neg_main ? (~prod_nxt + 1'b1) : prod_nxt;
        quo_fix  = job_q.neg_main ? (~quo_nxt + 1'b1) : quo_nxt;
        rem_fix  = job_q.neg_rem  ? (~rem_nxt + 1'b1) : rem_nxt;
    end

    hilo_mul_iter #(.W(W)) u_mul (
        .clk      (clk),
        .rst      (rst),
        .load     (launch && dec.is_mul),
        .step     (busy_q && !job_q.is_div),
        .mcand_in (a_mag),
        .mplier_in(b_mag),
        .prod_nxt (prod_nxt)
    );

    hilo_div_iter #(.W(W)) u_div (
        .clk        (clk),
        .rst        (rst),
        .load       (launch && dec.is_div),
        .step       (busy_q && job_q.is_div),
        .dividend_in(a_mag),
        .divisor_in (b_mag),
        .quo_nxt    (quo_nxt),
        .rem_nxt    (rem_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            lo_q   <= '0;
            busy_q <= 1'b0;
            cnt_q  <= '0;
            job_q  <= '0;
        end else begin
            if (launch) begin
                busy_q         <= 1'b1;
                cnt_q          <= '0;
                job_q.is_div   <= dec.is_div;
                job_q.neg_main <= a_neg ^ b_neg;
                job_q.neg_rem  <= a_neg;
                job_q.div_zero <= (rt_val == '0);
            end else if (busy_q) begin
                cnt_q <= cnt_q + 1'b1;
                if (finish) begin
                    busy_q <= 1'b0;
                    if (!job_q.is_div) begin
                        hi_q <= prod_fix[2*W-1:W];
                        lo_q <= prod_fix[W-1:0];
                    end else if (!job_q.div_zero) begin
                        hi_q <= rem_fix;
                        lo_q <= quo_fix;
                    end
                end
            end
            if (accept && dec.wr_hi) hi_q <= rs_val;
            if (accept && dec.wr_lo) lo_q <= rs_val;
        end
    end

    assign busy     = busy_q;
    assign rd_stall = rd_req && busy_q;
    assign rd_data  = rd_hi ? hi_q : lo_q;

endmodule

// File: rtl/hilo_muldiv_chk.sv
module hilo_muldiv_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [5:0]   funct,
    input logic [W-1:0] rs_val,
    input logic         busy,
    input logic         rd_req,
    input logic         rd_stall,
    input logic [W-1:0] hi_q,
    input logic [W-1:0] lo_q
);
    localparam int RC_W = $clog2(W) + 2;
    logic [RC_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)       run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else           run_cnt <= '0;
    end

    assert_reset_idle_R11: assert property (@(posedge clk)
        rst |=> (!busy && hi_q == '0 && lo_q == '0));

    assert_stall_R9: assert property (@(posedge clk) disable iff (rst)
        rd_stall == (rd_req && busy));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || ($stable(hi_q) && $stable(lo_q))));

    assert_run_len_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_cnt == RC_W'(W)));

    assert_move_hi_R5: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && funct == 6'd17) |=> (hi_q == $past(rs_val) && !busy));

    assert_move_lo_R5: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && funct == 6'd19) |=> (lo_q == $past(rs_val) && !busy));
endmodule

bind hilo_muldiv hilo_muldiv_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .funct   (funct),
    .rs_val  (rs_val),
    .busy    (busy),
    .rd_req  (rd_req),
    .rd_stall(rd_stall),
    .hi_q    (hi_q),
    .lo_q    (lo_q)
);

// File: tb/hilo_muldiv_tb.sv
module hilo_muldiv_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst, start, rd_req, rd_hi;
    logic [5:0]  funct;
    logic [31:0] rs_val, rt_val, rd_data;
    logic        rd_stall, busy;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [31:0] m_hi = '0, m_lo = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hilo_muldiv u_dut (
        .clk(clk), .rst(rst), .start(start), .funct(funct),
        .rs_val(rs_val), .rt_val(rt_val), .rd_req(rd_req), .rd_hi(rd_hi),
        .rd_data(rd_data), .rd_stall(rd_stall), .busy(busy)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_fail   = n_fail + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog expired act=%0d exp<%0d cycles", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic sel_hi, output logic [31:0] v);
        rd_hi = sel_hi;
        #1;
        v = rd_data;
    endtask

    task automatic check_regs(input string tag);
        logic [31:0] v;
        read_reg(1'b1, v); check(v === m_hi, {tag, " HI"}, v, m_hi);
        read_reg(1'b0, v); check(v === m_lo, {tag, " LO"}, v, m_lo);
    endtask

    task automatic model(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, sq, sr;
        logic [63:0] p;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (f)
            6'd24: begin p = 64'(sa * sb); m_hi = p[63:32]; m_lo = p[31:0]; end
            6'd25: begin p = {32'b0, a} * {32'b0, b}; m_hi = p[63:32]; m_lo = p[31:0]; end
            6'd26: if (b != 0) begin
                       sq = sa / sb; sr = sa % sb;
                       m_lo = sq[31:0]; m_hi = sr[31:0];
                   end
            6'd27: if (b != 0) begin m_lo = a / b; m_hi = a % b; end
            6'd17: m_hi = a;
            6'd19: m_lo = a;
            default: ;
        endcase
    endtask

    // launch one arithmetic op, count busy cycles, check a mid-run hold
    task automatic run_op(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b, input string tag);
        int n;
        logic [31:0] old_hi, v;
        old_hi = m_hi;
        @(negedge clk);
        start = 1'b1; funct = f; rs_val = a; rt_val = b;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (busy && n < 100) begin
            n++;
            if (n == 16) begin
                read_reg(1'b1, v);
                check(v === old_hi, "R7 hold during run", v, old_hi);
            end
            @(negedge clk);
        end
        check(n == 32, "R7 busy length", 32'(n), 32'd32);
        model(f, a, b);
        check_regs(tag);
    endtask

    task automatic move_op(input logic [5:0] f, input logic [31:0] a, input string tag);
        @(negedge clk);
        start = 1'b1; funct = f; rs_val = a; rt_val = '0;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b0, {tag, " busy"}, 32'(busy), 32'd0);
        model(f, a, '0);
        check_regs(tag);
    endtask

    initial begin
        logic [31:0] vals [10];
        logic [5:0]  ops [4];
        string tags [4];
        logic [31:0] v;
        vals = '{32'h0, 32'h1, 32'hffffffff, 32'h2, 32'h7, 32'hfffffff9,
                 32'h7fffffff, 32'h80000000, 32'h12345678, 32'hfffffffe};
        ops  = '{6'd24, 6'd25, 6'd26, 6'd27};
        tags = '{"R1", "R2", "R3", "R4"};

        rst = 1'b1; start = 1'b0; funct = '0; rs_val = '0; rt_val = '0;
        rd_req = 1'b0; rd_hi = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        check(busy === 1'b0, "R11 busy after reset", 32'(busy), 32'd0);
        check_regs("R11");

        // R5 and R6: direct moves and read select
        move_op(6'd17, 32'hcafe0001, "R5 mthi");
        move_op(6'd19, 32'h0bad0002, "R5 mtlo");
        read_reg(1'b1, v); check(v === 32'hcafe0001, "R6 select HI", v, 32'hcafe0001);
        read_reg(1'b0, v); check(v === 32'h0bad0002, "R6 select LO", v, 32'h0bad0002);

        // R10: unknown code ignored
        @(negedge clk);
        start = 1'b1; funct = 6'd32; rs_val = 32'h11111111; rt_val = 32'h2;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b0, "R10 unknown code busy", 32'(busy), 32'd0);
        check_regs("R10 unknown code");

        // R8: divide by zero keeps preset HI/LO
        run_op(6'd26, 32'h00000064, 32'h0, "R8 div zero");
        run_op(6'd27, 32'hffffffff, 32'h0, "R8 divu zero");

        // R9 stall and R10 start while busy
        @(negedge clk);
        start = 1'b1; funct = 6'd25; rs_val = 32'd1000; rt_val = 32'd3000;
        @(negedge clk);
        funct = 6'd17; rs_val = 32'hdeadbeef; rd_req = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(rd_stall === 1'b1, "R9 stall while busy", 32'(rd_stall), 32'd1);
        while (busy) @(negedge clk);
        check(rd_stall === 1'b0, "R9 no stall when idle", 32'(rd_stall), 32'd0);
        rd_req = 1'b0;
        model(6'd25, 32'd1000, 32'd3000);
        check_regs("R10 start while busy");

        // R1-style sweep over all boundary pairs for every arithmetic code
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    run_op(ops[k], vals[i], vals[j],
                           (vals[j] == 0 && k >= 2) ? "R8 sweep" : tags[k]);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule